// File: doc/BRIEF.md
# Link Sleep Negotiation Controller

This block sequences the low-power handshake of an automotive Ethernet PHY. From the Normal state, a local sleep command or a peer sleep request starts negotiation. The handshake then runs through Sleep Request or Sleep Ack, and then Sleep Silent. After a quiet period it settles in a final low-power state. A configuration bit picks whether that final state is Sleep or Standby. Negotiation is cancelled by an abort, by traffic, or by loss of link. A cancelled negotiation passes through Sleep Fail for one cycle and returns to Normal.

Software drives the block through two write ports. The first is a one-hot command port whose bits are held for one cycle only and are then cleared by hardware. The second is a configuration word that holds the policy bits and two override pairs: one forces sleep and one forces the WAKE pin. A wake command or a peer wake indication brings the controller out of Sleep or Standby. On that exit the WAKE output pulses for a fixed number of cycles.

Top module: `link_sleep_ctrl`

## Requirements
- R1: After reset the state is Normal (code 0), `wake_o`, `pwr_down_o` and `standby_o` are 0, and `auto_mode_o` is 1.
- R2: A command write sets `pend_cmd_o` to the written byte masked to bits 0 (go Normal), 1 (local sleep request), 4 (go Standby) and 7 (wake request) for exactly one cycle. The command takes effect on the following edge and the pending bits then clear without a write. Any other bit has no effect.
- R3: In Normal with link up, a sleep-request command moves to Sleep Request (code 1). A peer acknowledge then moves to Sleep Silent (code 3). Sleep Silent lasts SILENT_CYC cycles. It then enters Sleep (code 5) when `final_sleep` (cfg bit 1) is 1, and Standby (code 6) otherwise.
- R4: In Normal, a peer sleep request moves to Sleep Ack (code 2). Sleep Ack moves to Sleep Silent once the peer request drops.
- R5: In Sleep Ack, the register abort (cfg bit 4), or `abort_pin_i` high while its enable (cfg bit 5) is set, moves to Sleep Fail (code 4). Sleep Fail lasts one cycle and then returns to Normal. The abort has no effect in Sleep Request, and the pin has no effect while its enable is clear.
- R6: In Sleep Request or Sleep Ack, `activity_i` high moves to Sleep Fail when stop-on-activity (cfg bit 2, reset 1) is set. When that bit is clear, the state is unchanged.
- R7: In Sleep Request or Sleep Ack, `link_up_i` low moves to Sleep Fail when stop-on-link-down (cfg bit 3, reset 1) is set.
- R8: When both sleep-force bits (cfg bits 9 and 10) are 1, the next state is Sleep from any state. Either bit alone has no effect.
- R9: When the WAKE force enable (cfg bit 7) is set, `wake_o` equals the force value (cfg bit 8). Otherwise the controller drives `wake_o` itself.
- R10: In Sleep or Standby, a wake command or `peer_wake_i` returns the state to Normal. `wake_o` is then high for exactly WAKE_CYC cycles.
- R11: While the disable bit (cfg bit 0) is set, the state goes to Normal and stays there, and every command and peer request is ignored.
- R12: The autonomous-mode flag (cfg bit 6, `auto_mode_o`) clears on a rising edge of `link_up_i`. This clear overrides a write in the same cycle.
- R13: `pwr_down_o` is high only in Sleep and `standby_o` is high only in Standby. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 8 | One-hot command byte, write-1-to-set |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 11 | Configuration word |
| link_up_i | input | 1 | Link is established |
| activity_i | input | 1 | Traffic seen on the link |
| peer_sleep_req_i | input | 1 | Peer requests sleep |
| peer_sleep_ack_i | input | 1 | Peer acknowledges our request |
| peer_wake_i | input | 1 | Peer or local wake indication |
| abort_pin_i | input | 1 | External abort pin, active high |
| state_o | output | 3 | Current state code |
| wake_o | output | 1 | WAKE pin drive |
| pwr_down_o | output | 1 | Sleep power-down enable |
| standby_o | output | 1 | Standby enable |
| auto_mode_o | output | 1 | Autonomous-mode flag |
| pend_cmd_o | output | 8 | Pending command bits |

## Verification
A command written at edge k appears on `pend_cmd_o` after k, and the state it causes appears after edge k+1. A configuration write at edge k changes `wake_o` after k and changes the state after k+1. Status inputs such as peer request, activity, link and pin are set before edge k and move the state after k. The bench changes inputs on falling edges, advances whole cycles, and samples on the falling edge after the edge where each result is due. Sleep Silent and the WAKE pulse are counted sample by sample against SILENT_CYC and WAKE_CYC.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL  = 3'd0,
        ST_REQ     = 3'd1,
        ST_ACK     = 3'd2,
        ST_SILENT  = 3'd3,
        ST_FAIL    = 3'd4,
        ST_SLEEP   = 3'd5,
        ST_STANDBY = 3'd6
    } lps_state_e;

    // bit 0 is sm_off, bit 10 is slp_frc_val
    typedef struct packed {
        logic slp_frc_val;
        logic slp_frc_en;
        logic wake_frc_val;
        logic wake_frc_en;
        logic auto_mode;
        logic abort_pin_en;
        logic abort_reg;
        logic stop_on_linkdn;
        logic stop_on_act;
        logic final_sleep;
        logic sm_off;
    } lps_cfg_t;

    localparam int CFG_W = $bits(lps_cfg_t);
    localparam lps_cfg_t CFG_RST = 11'h04E;

    localparam int CMD_W       = 8;
    localparam int CMD_NORMAL  = 0;
    localparam int CMD_SLEEP   = 1;
    localparam int CMD_STANDBY = 4;
    localparam int CMD_WAKE    = 7;
    localparam logic [CMD_W-1:0] CMD_MASK =
        (8'd1 << CMD_NORMAL) | (8'd1 << CMD_SLEEP) |
        (8'd1 << CMD_STANDBY) | (8'd1 << CMD_WAKE);

endpackage

// File: rtl/lps_cfg_regs.sv
module lps_cfg_regs
    import lps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    input  logic             cfg_wr_i,
    input  lps_cfg_t         cfg_wdata_i,
    input  logic             link_up_i,
    output lps_cfg_t         cfg_o,
    output logic [CMD_W-1:0] pend_o
);
    typedef struct packed {
        lps_cfg_t         cfg;
        logic [CMD_W-1:0] pend;
        logic             link_prev;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        r_d.link_prev = link_up_i;
        // pending bits live for one cycle only; hardware clears them
        r_d.pend = cmd_wr_i ? (cmd_wdata_i & CMD_MASK) : '0;
        if (cfg_wr_i) begin
            r_d.cfg = cfg_wdata_i;
        end
        // link rising edge clears the autonomous flag, ahead of a write
        if (link_up_i && !r_q.link_prev) begin
            r_d.cfg.auto_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cfg       <= CFG_RST;
            r_q.pend      <= '0;
            r_q.link_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_o  = r_q.cfg;
    assign pend_o = r_q.pend;

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
#(
    parameter int unsigned SILENT_CYC = 8,
    parameter int unsigned WAKE_CYC   = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sm_off_i,
    input  logic       final_sleep_i,
    input  logic       stop_act_i,
    input  logic       stop_ld_i,
    input  logic       abort_reg_i,
    input  logic       abort_pin_en_i,
    input  logic       slp_force_i,
    input  logic       cmd_normal_i,
    input  logic       cmd_sleep_i,
    input  logic       cmd_standby_i,
    input  logic       cmd_wake_i,
    input  logic       link_up_i,
    input  logic       activity_i,
    input  logic       peer_req_i,
    input  logic       peer_ack_i,
    input  logic       peer_wake_i,
    input  logic       abort_pin_i,
    output lps_state_e state_o,
    output logic       wake_busy_o
);
    localparam int SIL_W  = $clog2(SILENT_CYC + 1);
    localparam int WAKE_W = $clog2(WAKE_CYC + 1);
    localparam logic [SIL_W-1:0]  SIL_LAST  = SIL_W'(SILENT_CYC - 1);
    localparam logic [WAKE_W-1:0] WAKE_LOAD = WAKE_W'(WAKE_CYC);

    typedef struct packed {
        lps_state_e        state;
        logic [SIL_W-1:0]  sil_cnt;
        logic [WAKE_W-1:0] wake_cnt;
    } fsm_t;

    fsm_t r_q, r_d;
    logic stop_hit, abort_hit;

    always_comb begin
        r_d       = r_q;
        stop_hit  = (activity_i && stop_act_i) || (!link_up_i && stop_ld_i);
        abort_hit = abort_reg_i || (abort_pin_en_i && abort_pin_i);
        if (r_q.wake_cnt != '0) begin
            r_d.wake_cnt = r_q.wake_cnt - 1'b1;
        end
        if (r_q.state != ST_SILENT) begin
            r_d.sil_cnt = '0;
        end
        if (sm_off_i) begin
            r_d.state = ST_NORMAL;
        end else if (slp_force_i) begin
            r_d.state = ST_SLEEP;
        end else if (cmd_normal_i) begin
            r_d.state = ST_NORMAL;
        end else begin
            unique case (r_q.state)
                ST_NORMAL: begin
                    if (cmd_sleep_i && link_up_i) r_d.state = ST_REQ;
                    else if (cmd_standby_i)       r_d.state = ST_STANDBY;
                    else if (peer_req_i)          r_d.state = ST_ACK;
                end
                ST_REQ: begin
                    if (stop_hit)        r_d.state = ST_FAIL;
                    else if (peer_ack_i) r_d.state = ST_SILENT;
                end
                ST_ACK: begin
                    if (abort_hit || stop_hit) r_d.state = ST_FAIL;
                    else if (!peer_req_i)      r_d.state = ST_SILENT;
                end
                ST_SILENT: begin
                    if (r_q.sil_cnt == SIL_LAST) begin
                        r_d.state = final_sleep_i ? ST_SLEEP : ST_STANDBY;
                    end else begin
                        r_d.sil_cnt = r_q.sil_cnt + 1'b1;
                    end
                end
                ST_FAIL: r_d.state = ST_NORMAL;
                ST_SLEEP, ST_STANDBY: begin
                    if (cmd_wake_i || peer_wake_i) begin
                        r_d.state    = ST_NORMAL;
                        r_d.wake_cnt = WAKE_LOAD;
                    end
                end
                default: r_d.state = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_NORMAL;
            r_q.sil_cnt  <= '0;
            r_q.wake_cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o     = r_q.state;
    assign wake_busy_o = (r_q.wake_cnt != '0);

endmodule

// File: rtl/lps_pin_drv.sv
module lps_pin_drv
    import lps_pkg::*;
(
    input  lps_state_e state_i,
    input  logic       wake_busy_i,
    input  logic       wake_frc_en_i,
    input  logic       wake_frc_val_i,
    output logic       wake_o,
    output logic       pwr_down_o,
    output logic       standby_o
);
    always_comb begin
        wake_o     = wake_frc_en_i ? wake_frc_val_i : wake_busy_i;
        pwr_down_o = (state_i == ST_SLEEP);
        standby_o  = (state_i == ST_STANDBY);
    end
endmodule

// File: rtl/link_sleep_ctrl.sv
module link_sleep_ctrl
    import lps_pkg::*;
#(
    parameter int unsigned SILENT_CYC = 8,
    parameter int unsigned WAKE_CYC   = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr_i,
    input  logic [7:0]  cmd_wdata_i,
    input  logic        cfg_wr_i,
    input  logic [10:0] cfg_wdata_i,
    input  logic        link_up_i,
    input  logic        activity_i,
    input  logic        peer_sleep_req_i,
    input  logic        peer_sleep_ack_i,
    input  logic        peer_wake_i,
    input  logic        abort_pin_i,
    output logic [2:0]  state_o,
    output logic        wake_o,
    output logic        pwr_down_o,
    output logic        standby_o,
    output logic        auto_mode_o,
    output logic [7:0]  pend_cmd_o
);
    lps_cfg_t         cfg;
    logic [CMD_W-1:0] pend;
    lps_state_e       state;
    logic             wake_busy;

    lps_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr_i),
        .cmd_wdata_i (cmd_wdata_i),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_wdata_i (lps_cfg_t'(cfg_wdata_i)),
        .link_up_i   (link_up_i),
        .cfg_o       (cfg),
        .pend_o      (pend)
    );

    lps_fsm #(
        .SILENT_CYC (SILENT_CYC),
        .WAKE_CYC   (WAKE_CYC)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sm_off_i       (cfg.sm_off),
        .final_sleep_i  (cfg.final_sleep),
        .stop_act_i     (cfg.stop_on_act),
        .stop_ld_i      (cfg.stop_on_linkdn),
        .abort_reg_i    (cfg.abort_reg),
        .abort_pin_en_i (cfg.abort_pin_en),
        .slp_force_i    (cfg.slp_frc_en && cfg.slp_frc_val),
        .cmd_normal_i   (pend[CMD_NORMAL]),
        .cmd_sleep_i    (pend[CMD_SLEEP]),
        .cmd_standby_i  (pend[CMD_STANDBY]),
        .cmd_wake_i     (pend[CMD_WAKE]),
        .link_up_i      (link_up_i),
        .activity_i     (activity_i),
        .peer_req_i     (peer_sleep_req_i),
        .peer_ack_i     (peer_sleep_ack_i),
        .peer_wake_i    (peer_wake_i),
        .abort_pin_i    (abort_pin_i),
        .state_o        (state),
        .wake_busy_o    (wake_busy)
    );

    lps_pin_drv u_drv (
        .state_i        (state),
        .wake_busy_i    (wake_busy),
        .wake_frc_en_i  (cfg.wake_frc_en),
        .wake_frc_val_i (cfg.wake_frc_val),
        .wake_o         (wake_o),
        .pwr_down_o     (pwr_down_o),
        .standby_o      (standby_o)
    );

    assign state_o     = state;
    assign auto_mode_o = cfg.auto_mode;
    assign pend_cmd_o  = pend;

endmodule

// File: rtl/link_sleep_ctrl_checker.sv
module link_sleep_ctrl_checker
    import lps_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr_i,
    input logic [7:0] pend_cmd_o,
    input logic [2:0] state_o,
    input lps_cfg_t   cfg,
    input logic       link_up_i,
    input logic       abort_pin_i,
    input logic       auto_mode_o,
    input logic       pwr_down_o,
    input logic       standby_o
);
    logic force_on;
    assign force_on = cfg.slp_frc_en && cfg.slp_frc_val;

    a_r2_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr_i |=> pend_cmd_o == 8'h00);

    a_r5_abort_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACK) && (cfg.abort_reg || (cfg.abort_pin_en && abort_pin_i))
        && !cfg.sm_off && !force_on && !pend_cmd_o[CMD_NORMAL]
        |=> state_o == ST_FAIL);

    a_r5_fail_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_FAIL |=> state_o != ST_FAIL);

    a_r8_force_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        force_on && !cfg.sm_off |=> state_o == ST_SLEEP);

    a_r11_disabled_normal: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.sm_off |=> state_o == ST_NORMAL);

    a_r12_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_i) |=> !auto_mode_o);

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down_o && standby_o));

endmodule

bind link_sleep_ctrl link_sleep_ctrl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (cmd_wr_i),
    .pend_cmd_o  (pend_cmd_o),
    .state_o     (state_o),
    .cfg         (cfg),
    .link_up_i   (link_up_i),
    .abort_pin_i (abort_pin_i),
    .auto_mode_o (auto_mode_o),
    .pwr_down_o  (pwr_down_o),
    .standby_o   (standby_o)
);

// File: tb/test_link_sleep_ctrl.sv
`timescale 1ns/1ps
module test_link_sleep_ctrl;
    localparam int SIL  = 8;
    localparam int WAKE = 5;
    localparam logic [10:0] DEF = 11'h04E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_wdata = '0;
    logic        cfg_wr = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        link_up = 1'b0, activity = 1'b0, peer_req = 1'b0;
    logic        peer_ack = 1'b0, peer_wake = 1'b0, abort_pin = 1'b0;
    logic [2:0]  state;
    logic        wake, pwr_down, standby, auto_mode;
    logic [7:0]  pend;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    link_sleep_ctrl #(.SILENT_CYC(SIL), .WAKE_CYC(WAKE)) i_link_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
        .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .link_up_i(link_up),
        .activity_i(activity), .peer_sleep_req_i(peer_req),
        .peer_sleep_ack_i(peer_ack), .peer_wake_i(peer_wake),
        .abort_pin_i(abort_pin), .state_o(state), .wake_o(wake),
        .pwr_down_o(pwr_down), .standby_o(standby), .auto_mode_o(auto_mode),
        .pend_cmd_o(pend)
    );

    function automatic logic [7:0] exp_pend(input logic [7:0] d);
        return d & 8'h93;
    endfunction

    function automatic logic exp_wake_forced(input logic en, input logic val, input logic own);
        return en ? val : own;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [10:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; tick(); cfg_wr = 1'b0;
    endtask

    task automatic wcmd(input logic [7:0] v);
        cmd_wr = 1'b1; cmd_wdata = v; tick(); cmd_wr = 1'b0;
    endtask

    task automatic silent_to_final(input int exp_final, input string req);
        chk({req, " enter silent"}, state, 3);
        for (int i = 0; i < SIL - 1; i++) tick();
        chk({req, " silent held"}, state, 3);
        tick();
        chk({req, " final state"}, state, exp_final);
    endtask

    task automatic wake_len(input string req);
        int n = 0;
        for (int i = 0; i < WAKE + 3; i++) begin
            if (wake) n++;
            tick();
        end
        chk(req, n, WAKE);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 state", state, 0);
        chk("R1 wake", wake, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 standby", standby, 0);
        chk("R1 auto_mode", auto_mode, 1);

        // R12 autonomous flag clears on link rise
        link_up = 1'b1; tick();
        chk("R12 auto cleared", auto_mode, 0);

        // R2 / R3 local request to sleep
        wcmd(8'h02);
        chk("R2 pend visible", pend, 8'h02);
        tick();
        chk("R2 pend cleared", pend, 0);
        chk("R3 sleep request", state, 1);
        peer_ack = 1'b1; tick(); peer_ack = 1'b0;
        silent_to_final(5, "R3");
        chk("R13 pwr_down in sleep", pwr_down, 1);
        chk("R13 standby off in sleep", standby, 0);

        // R10 wake by command
        wcmd(8'h80); tick();
        chk("R10 normal after wake cmd", state, 0);
        wake_len("R10 wake pulse cmd");

        // R4 peer path into standby
        wcfg(DEF & ~11'h002);
        peer_req = 1'b1; tick();
        chk("R4 sleep ack", state, 2);
        peer_req = 1'b0; tick();
        silent_to_final(6, "R4");
        chk("R13 standby in standby", standby, 1);
        chk("R13 pwr_down off in standby", pwr_down, 0);
        peer_wake = 1'b1; tick(); peer_wake = 1'b0;
        chk("R10 normal after peer wake", state, 0);
        wake_len("R10 wake pulse peer");
        wcfg(DEF);

        // R5 register abort: no effect in request, fails from ack
        wcfg(DEF | 11'h010);
        wcmd(8'h02); tick(); tick();
        chk("R5 abort ignored in request", state, 1);
        wcmd(8'h01); tick();
        chk("R2 normal command", state, 0);
        peer_req = 1'b1; tick();
        chk("R5 ack", state, 2);
        tick();
        chk("R5 fail on reg abort", state, 4);
        peer_req = 1'b0; tick();
        chk("R5 back to normal", state, 0);

        // R5 pin abort with enable
        wcfg(DEF | 11'h020);
        abort_pin = 1'b1; peer_req = 1'b1; tick();
        chk("R5 ack pin", state, 2);
        tick();
        chk("R5 fail on pin", state, 4);
        peer_req = 1'b0; tick();
        chk("R5 normal after pin", state, 0);

        // R5 pin ignored without enable, then R6 activity stop
        wcfg(DEF);
        peer_req = 1'b1; tick(); tick();
        chk("R5 pin ignored when disabled", state, 2);
        abort_pin = 1'b0; activity = 1'b1; tick();
        chk("R6 fail on activity", state, 4);
        activity = 1'b0; peer_req = 1'b0; tick();
        chk("R6 normal", state, 0);

        // R6 continue despite activity, R7 link loss
        wcfg(DEF & ~11'h004);
        peer_req = 1'b1; tick();
        activity = 1'b1; tick();
        chk("R6 activity ignored when clear", state, 2);
        link_up = 1'b0; tick();
        chk("R7 fail on link down", state, 4);
        activity = 1'b0; peer_req = 1'b0; link_up = 1'b1; tick();
        chk("R7 normal", state, 0);
        wcfg(DEF);

        // R8 force sleep
        wcfg(DEF | 11'h200); tick();
        chk("R8 one force bit no effect", state, 0);
        wcfg(DEF | 11'h600); tick();
        chk("R8 forced sleep", state, 5);
        wcfg(DEF); tick();
        chk("R8 remains sleep", state, 5);
        wcmd(8'h01); tick();
        chk("R2 normal from sleep", state, 0);

        // R11 disable
        peer_req = 1'b1; tick();
        chk("R11 ack before disable", state, 2);
        wcfg(DEF | 11'h001); tick();
        chk("R11 forced normal", state, 0);
        tick();
        chk("R11 peer request ignored", state, 0);
        wcmd(8'h10); tick();
        chk("R11 standby cmd ignored", state, 0);
        peer_req = 1'b0;
        wcfg(DEF); tick();

        // R2 standby command
        wcmd(8'h10); tick();
        chk("R2 standby command", state, 6);
        wcmd(8'h80); tick();
        chk("R2 wake command", state, 0);
        repeat (WAKE + 2) tick();

        // R2 random commands with only ignored or harmless bits
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d;
            d = 8'($urandom) & ~8'h12;
            wcmd(d);
            chk("R2 random pend", pend, exp_pend(d));
            tick();
            chk("R2 random clear", pend, 0);
            chk("R2 random state", state, 0);
        end

        // R9 random WAKE overrides
        for (int i = 0; i < 30; i++) begin
            logic en, val;
            en  = 1'($urandom);
            val = 1'($urandom);
            wcfg(DEF | ({10'd0, en} << 7) | ({10'd0, val} << 8));
            chk("R9 wake drive", wake, exp_wake_forced(en, val, 1'b0));
        end
        wcfg(DEF);
        tick();
        chk("R9 wake released", wake, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule